// File: doc/BRIEF.md
# Reuse-Filtered Victim Cache Controller

This block is a small shared victim store that sits below a private upper-level cache and above main memory. Lines enter it only when the upper level evicts them. Each eviction record carries a line address, a data payload, a modified flag and a small counter of the hits the line collected while it was resident above. A line that was never reused up there is taken to be dead and is not kept. A line that was reused is installed. A modified line is always passed to the memory write port, whether or not it is also installed, so the victim store holds only clean copies. Replacing a victim entry therefore just overwrites it.

The upper level probes the store on its own misses. A probe reports hit or miss one cycle after it is presented. A hit returns the payload and removes the line from the victim store, because the two levels are exclusive. The ways of each set are replaced under a binary-tree pseudo-LRU. An empty way is always filled before any line is displaced. While a memory write is waiting for the memory side to accept it, no new eviction is taken.

Top module: `vc_victim_ctrl`

## Requirements
- R1: After reset `evict_ready` is 1, `mem_valid` and `resp_valid` are 0, and every lookup misses, because all entries are invalid.
- R2: An accepted eviction whose `evict_hits` is zero is not installed: a later lookup of that address misses.
- R3: An accepted eviction with nonzero `evict_hits` is installed. A lookup presented in cycle n gives `resp_valid`=1 in cycle n+1, with `resp_hit`=1 and `resp_data` equal to the installed payload on a hit. On a miss `resp_hit`=0 and `resp_data`=0.
- R4: Every accepted eviction with `evict_dirty`=1 produces one memory write carrying its address and payload, whatever its hit count. An eviction with `evict_dirty`=0 produces none.
- R5: A lookup that hits invalidates the line, so a second lookup of the same address misses.
- R6: While `mem_valid`=1, `evict_ready` is 0, and `mem_addr` and `mem_data` hold steady until `mem_ready` is seen. An eviction offered during that time is not taken.
- R7: The line address splits into a set index in the low `log2(SETS)` bits and a tag in the rest. An install uses the lowest-numbered invalid way of its set. When the set is full, it replaces the way chosen by a binary tree of WAYS-1 bits, where each node bit is 0 for the lower half and 1 for the upper half. Every install sets each node on the path to point away from the way just written. A lookup does not change the tree.
- R8: When a lookup and an accepted eviction carry the same address in the same cycle, the eviction wins: the lookup reports a miss and the eviction is processed normally.
- R9: Installing an address that is already present overwrites that entry in place: the next lookup returns the newer payload and the one after it misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evict_valid | input | 1 | Eviction record offered |
| evict_ready | output | 1 | Eviction record can be taken |
| evict_addr | input | ADDR_W | Line address of the evicted line |
| evict_data | input | DATA_W | Line payload |
| evict_dirty | input | 1 | Line was modified in the upper level |
| evict_hits | input | HIT_W | Hits the line saw in the upper level |
| lookup_valid | input | 1 | Probe from an upper-level miss |
| lookup_addr | input | ADDR_W | Line address probed |
| resp_valid | output | 1 | Probe result valid, one cycle after the probe |
| resp_hit | output | 1 | Probe hit |
| resp_data | output | DATA_W | Payload on hit, zero on miss |
| mem_valid | output | 1 | Memory write pending |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | ADDR_W | Memory write address |
| mem_data | output | DATA_W | Memory write payload |

## Verification
The properties assume that a probe needs no handshake and is always taken, and that the memory side may hold `mem_ready` low for any number of cycles. They also assume the upper level offers an eviction on `evict_valid` and waits for `evict_ready` before it drops the record. The stimulus drives each eviction until it is accepted and never withdraws one, except in the stall test. There it deliberately offers and then withdraws a record while the write slot is full, to show that the record was not taken. Lookups are single-cycle pulses, and `mem_ready` is low only during the stall test.

// File: rtl/vc_pkg.sv
package vc_pkg;
  typedef enum logic [1:0] {
    INS_NONE    = 2'd0,
    INS_REFRESH = 2'd1,
    INS_FREE    = 2'd2,
    INS_REPLACE = 2'd3
  } ins_kind_e;
endpackage

// File: rtl/vc_rst_sync.sv
module vc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_n_sync <= stage_q;
    end
  end
endmodule

// File: rtl/vc_set_match.sv
module vc_set_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 10,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]       way_valid,
  input  logic [WAYS*TAG_W-1:0] way_tags,
  input  logic [TAG_W-1:0]      probe_tag,
  output logic                  hit_any,
  output logic [WAY_W-1:0]      hit_way
);
  logic [WAYS-1:0] hit_vec;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = way_valid[w] && (way_tags[w*TAG_W +: TAG_W] == probe_tag);
  end

  always_comb begin
    hit_any = |hit_vec;
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
  end
endmodule

// File: rtl/vc_plru.sv
module vc_plru #(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS),
  localparam int PL_W  = WAYS - 1
) (
  input  logic [PL_W-1:0]  tree_state,
  input  logic [WAY_W-1:0] touch_way,
  output logic [WAY_W-1:0] victim_way,
  output logic [PL_W-1:0]  tree_next
);
  int node;
  int leaf;
  int parent;

  always_comb begin
    node = 1;
    for (int lvl = 0; lvl < WAY_W; lvl++) begin
      node = node * 2 + (tree_state[node-1] ? 1 : 0);
    end
    victim_way = WAY_W'(node - WAYS);
  end

  always_comb begin
    tree_next = tree_state;
    leaf      = int'(touch_way) + WAYS;
    parent    = 1;
    for (int lvl = 0; lvl < WAY_W; lvl++) begin
      parent = leaf / 2;
      tree_next[parent-1] = ((leaf % 2) == 0);
      leaf = parent;
    end
  end
endmodule

// File: rtl/vc_wr_slot.sv
module vc_wr_slot #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [DATA_W-1:0] load_data,
  input  logic              mem_ready,
  output logic              mem_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data
);
  logic pend_d;

  always_comb begin
    pend_d = mem_valid;
    if (mem_valid && mem_ready) pend_d = 1'b0;
    if (load)                   pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mem_valid <= 1'b0;
    else        mem_valid <= pend_d;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      mem_addr <= load_addr;
      mem_data <= load_data;
    end
  end
endmodule

// File: rtl/vc_victim_ctrl.sv
module vc_victim_ctrl
  import vc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64,
  parameter int HIT_W  = 3,
  parameter int SETS   = 64,
  parameter int WAYS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evict_valid,
  output logic              evict_ready,
  input  logic [ADDR_W-1:0] evict_addr,
  input  logic [DATA_W-1:0] evict_data,
  input  logic              evict_dirty,
  input  logic [HIT_W-1:0]  evict_hits,
  input  logic              lookup_valid,
  input  logic [ADDR_W-1:0] lookup_addr,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [DATA_W-1:0] resp_data,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data
);
  localparam int SET_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - SET_W;
  localparam int WAY_W = $clog2(WAYS);
  localparam int PL_W  = WAYS - 1;

  logic rst_n_s;

  logic [WAYS-1:0]   valid_q [SETS];
  logic [PL_W-1:0]   plru_q  [SETS];
  logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
  logic [DATA_W-1:0] data_q  [SETS][WAYS];

  logic [SET_W-1:0] e_set, l_set;
  logic [TAG_W-1:0] e_tag, l_tag;
  logic [WAYS*TAG_W-1:0] e_tags, l_tags;
  logic             e_hit_any, l_hit_any;
  logic [WAY_W-1:0] e_hit_way, l_hit_way;

  logic evict_take, keep_line, same_line, look_hit;
  logic             free_any;
  logic [WAY_W-1:0] free_way, plru_victim, ins_way;
  logic [PL_W-1:0]  plru_next;
  ins_kind_e        ins_kind;

  logic              resp_valid_d, resp_hit_d;
  logic [DATA_W-1:0] resp_data_d;

  vc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  assign e_set = evict_addr[SET_W-1:0];
  assign e_tag = evict_addr[ADDR_W-1:SET_W];
  assign l_set = lookup_addr[SET_W-1:0];
  assign l_tag = lookup_addr[ADDR_W-1:SET_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_tags
    assign e_tags[w*TAG_W +: TAG_W] = tag_q[e_set][w];
    assign l_tags[w*TAG_W +: TAG_W] = tag_q[l_set][w];
  end

  vc_set_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match_evict (
    .way_valid (valid_q[e_set]),
    .way_tags  (e_tags),
    .probe_tag (e_tag),
    .hit_any   (e_hit_any),
    .hit_way   (e_hit_way)
  );

  vc_set_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match_look (
    .way_valid (valid_q[l_set]),
    .way_tags  (l_tags),
    .probe_tag (l_tag),
    .hit_any   (l_hit_any),
    .hit_way   (l_hit_way)
  );

  // Eviction accepted only when the memory write slot is empty.
  assign evict_ready = !mem_valid;
  assign evict_take  = evict_valid && evict_ready;
  assign keep_line   = evict_take && (evict_hits != '0);
  assign same_line   = lookup_valid && evict_take && (lookup_addr == evict_addr);
  assign look_hit    = lookup_valid && l_hit_any && !same_line;

  always_comb begin
    free_any = 1'b0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_q[e_set][w]) begin
        free_any = 1'b1;
        free_way = WAY_W'(w);
      end
    end
  end

  vc_plru #(.WAYS(WAYS)) u_plru (
    .tree_state (plru_q[e_set]),
    .touch_way  (ins_way),
    .victim_way (plru_victim),
    .tree_next  (plru_next)
  );

  always_comb begin
    ins_kind = INS_NONE;
    ins_way  = plru_victim;
    if (keep_line) begin
      if (e_hit_any) begin
        ins_kind = INS_REFRESH;
        ins_way  = e_hit_way;
      end else if (free_any) begin
        ins_kind = INS_FREE;
        ins_way  = free_way;
      end else begin
        ins_kind = INS_REPLACE;
      end
    end
  end

  // Invalidate on hit first; a same-cycle install to that way wins.
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        plru_q[s]  <= '0;
      end
    end else begin
      if (look_hit) valid_q[l_set][l_hit_way] <= 1'b0;
      if (ins_kind != INS_NONE) begin
        valid_q[e_set][ins_way] <= 1'b1;
        plru_q[e_set]           <= plru_next;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ins_kind != INS_NONE) begin
      tag_q[e_set][ins_way]  <= e_tag;
      data_q[e_set][ins_way] <= evict_data;
    end
  end

  always_comb begin
    resp_valid_d = lookup_valid;
    resp_hit_d   = look_hit;
    resp_data_d  = look_hit ? data_q[l_set][l_hit_way] : '0;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_data  <= '0;
    end else begin
      resp_valid <= resp_valid_d;
      resp_hit   <= resp_hit_d;
      resp_data  <= resp_data_d;
    end
  end

  vc_wr_slot #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .load      (evict_take && evict_dirty),
    .load_addr (evict_addr),
    .load_data (evict_data),
    .mem_ready (mem_ready),
    .mem_valid (mem_valid),
    .mem_addr  (mem_addr),
    .mem_data  (mem_data)
  );
endmodule

// File: rtl/vc_victim_ctrl_chk.sv
module vc_victim_ctrl_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64,
  parameter int HIT_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              evict_valid,
  input logic              evict_ready,
  input logic [ADDR_W-1:0] evict_addr,
  input logic [DATA_W-1:0] evict_data,
  input logic              evict_dirty,
  input logic [HIT_W-1:0]  evict_hits,
  input logic              lookup_valid,
  input logic [ADDR_W-1:0] lookup_addr,
  input logic              resp_valid,
  input logic              resp_hit,
  input logic [DATA_W-1:0] resp_data,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_data
);
  logic take;
  assign take = evict_valid && evict_ready;

  p_resp_lat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_valid |=> resp_valid);

  p_resp_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !lookup_valid |=> !resp_valid);

  p_miss_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_hit) |-> (resp_data == '0));

  p_dirty_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && evict_dirty) |=> (mem_valid && mem_addr == $past(evict_addr)
                               && mem_data == $past(evict_data)));

  p_clean_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !evict_dirty) |=> !mem_valid);

  p_dead_no_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && evict_hits == '0 && lookup_valid && lookup_addr == evict_addr) |=> !resp_hit);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

  p_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !evict_ready);

  p_same_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && lookup_valid && lookup_addr == evict_addr) |=> !resp_hit);
endmodule

bind vc_victim_ctrl vc_victim_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .HIT_W  (HIT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n_s),
  .evict_valid  (evict_valid),
  .evict_ready  (evict_ready),
  .evict_addr   (evict_addr),
  .evict_data   (evict_data),
  .evict_dirty  (evict_dirty),
  .evict_hits   (evict_hits),
  .lookup_valid (lookup_valid),
  .lookup_addr  (lookup_addr),
  .resp_valid   (resp_valid),
  .resp_hit     (resp_hit),
  .resp_data    (resp_data),
  .mem_valid    (mem_valid),
  .mem_ready    (mem_ready),
  .mem_addr     (mem_addr),
  .mem_data     (mem_data)
);

// File: tb/tb_vc_victim_ctrl.sv
module tb_vc_victim_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 64;
  localparam int HIT_W  = 3;
  localparam int SET_W  = 6;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              evict_valid, evict_ready, evict_dirty;
  logic [ADDR_W-1:0] evict_addr;
  logic [DATA_W-1:0] evict_data;
  logic [HIT_W-1:0]  evict_hits;
  logic              lookup_valid;
  logic [ADDR_W-1:0] lookup_addr;
  logic              resp_valid, resp_hit;
  logic [DATA_W-1:0] resp_data;
  logic              mem_valid, mem_ready;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_data;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [DATA_W:0]          exp_resp_q[$];
  string                    resp_req_q[$];
  logic [ADDR_W+DATA_W-1:0] exp_mem_q[$];
  string                    mem_req_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  vc_victim_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .evict_valid(evict_valid), .evict_ready(evict_ready), .evict_addr(evict_addr),
    .evict_data(evict_data), .evict_dirty(evict_dirty), .evict_hits(evict_hits),
    .lookup_valid(lookup_valid), .lookup_addr(lookup_addr),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_data(resp_data),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data)
  );

  function automatic logic [ADDR_W-1:0] mk(input int tag, input int set);
    return ADDR_W'((tag << SET_W) | set);
  endfunction

  task automatic check(input bit ok, input string req, input logic [DATA_W:0] act,
                       input logic [DATA_W:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: compares produced results against the scoreboard queues.
  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      if (exp_resp_q.size() == 0) check(1'b0, "R3 unexpected response", {resp_hit, resp_data}, '0);
      else begin
        logic [DATA_W:0] e;
        string r;
        e = exp_resp_q.pop_front();
        r = resp_req_q.pop_front();
        check({resp_hit, resp_data} == e, r, {resp_hit, resp_data}, e);
      end
    end
    if (rst_n && mem_valid && mem_ready) begin
      if (exp_mem_q.size() == 0) check(1'b0, "R4 unexpected memory write", {1'b0, mem_data}, '0);
      else begin
        logic [ADDR_W+DATA_W-1:0] m;
        string r;
        m = exp_mem_q.pop_front();
        r = mem_req_q.pop_front();
        check({mem_addr, mem_data} == m, r, {1'b0, mem_data}, {1'b0, m[DATA_W-1:0]});
      end
    end
  end

  task automatic evict(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                       input bit dirty, input int hits, input string req);
    if (dirty) begin
      exp_mem_q.push_back({a, d});
      mem_req_q.push_back(req);
    end
    evict_valid = 1'b1; evict_addr = a; evict_data = d;
    evict_dirty = dirty; evict_hits = HIT_W'(hits);
    while (!evict_ready) begin @(posedge clk); #1; end
    @(posedge clk); #1;
    evict_valid = 1'b0;
  endtask

  task automatic lookup(input logic [ADDR_W-1:0] a, input bit hit,
                        input logic [DATA_W-1:0] d, input string req);
    exp_resp_q.push_back({hit, hit ? d : {DATA_W{1'b0}}});
    resp_req_q.push_back(req);
    lookup_valid = 1'b1; lookup_addr = a;
    @(posedge clk); #1;
    lookup_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    evict_valid = 0; evict_addr = '0; evict_data = '0; evict_dirty = 0; evict_hits = '0;
    lookup_valid = 0; lookup_addr = '0; mem_ready = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R1: idle outputs and empty store after reset
    check(evict_ready == 1'b1, "R1 evict_ready", {{DATA_W{1'b0}}, evict_ready}, 1);
    check(mem_valid == 1'b0, "R1 mem_valid", {{DATA_W{1'b0}}, mem_valid}, 0);
    check(resp_valid == 1'b0, "R1 resp_valid", {{DATA_W{1'b0}}, resp_valid}, 0);
    lookup(mk(1, 0), 0, '0, "R1 lookup after reset");
    lookup(mk(3, 63), 0, '0, "R1 lookup after reset");

    // R2: dead clean line dropped
    evict(mk(2, 1), 64'h1111, 0, 0, "R2");
    lookup(mk(2, 1), 0, '0, "R2 dead clean line not kept");
    // R2/R4: dead dirty line written to memory but not kept
    evict(mk(4, 2), 64'h2222_0000_dead, 1, 0, "R4 dead dirty write");
    @(posedge clk); #1;
    lookup(mk(4, 2), 0, '0, "R2 dead dirty line not kept");

    // R3/R4: reused dirty line written and kept
    evict(mk(5, 3), 64'hA5A5_0003, 1, 2, "R4 reused dirty write");
    @(posedge clk); #1;
    lookup(mk(5, 3), 1, 64'hA5A5_0003, "R3 reused line hit");
    // R5: exclusive, second lookup misses
    lookup(mk(5, 3), 0, '0, "R5 hit invalidates");

    // R3: clean reused line installed, no memory write
    evict(mk(6, 4), 64'hC0FFEE, 0, 7, "R4");
    lookup(mk(6, 4), 1, 64'hC0FFEE, "R3 clean reused hit");

    // R9: reinstall overwrites in place
    evict(mk(7, 5), 64'h1, 0, 1, "R9");
    evict(mk(7, 5), 64'h2, 0, 3, "R9");
    lookup(mk(7, 5), 1, 64'h2, "R9 newer payload");
    lookup(mk(7, 5), 0, '0, "R9 no stale duplicate");

    // R7: fill set 9, then replace under the tree order
    evict(mk(10, 9), 64'hA, 0, 1, "R7");
    evict(mk(11, 9), 64'hB, 0, 1, "R7");
    evict(mk(12, 9), 64'hC, 0, 1, "R7");
    evict(mk(13, 9), 64'hD, 0, 1, "R7");
    evict(mk(14, 9), 64'hE, 0, 1, "R7");
    lookup(mk(10, 9), 0, '0, "R7 first victim is way 0");
    evict(mk(15, 9), 64'hF, 0, 1, "R7");
    lookup(mk(12, 9), 0, '0, "R7 second victim is way 2");
    lookup(mk(11, 9), 1, 64'hB, "R7 way 1 kept");
    lookup(mk(13, 9), 1, 64'hD, "R7 way 3 kept");
    lookup(mk(14, 9), 1, 64'hE, "R7 new line E");
    lookup(mk(15, 9), 1, 64'hF, "R7 new line F");

    // R8: same-address lookup and eviction in one cycle
    exp_resp_q.push_back('0);
    resp_req_q.push_back("R8 simultaneous lookup misses");
    evict_valid = 1; evict_addr = mk(20, 11); evict_data = 64'h88; evict_dirty = 0;
    evict_hits = 3'd1; lookup_valid = 1; lookup_addr = mk(20, 11);
    @(posedge clk); #1;
    evict_valid = 0; lookup_valid = 0;
    lookup(mk(20, 11), 1, 64'h88, "R8 eviction still installed");

    // R6: memory back-pressure stalls evictions
    mem_ready = 1'b0;
    evict(mk(30, 12), 64'h6666, 1, 0, "R6 stalled write");
    evict_valid = 1; evict_addr = mk(31, 13); evict_data = 64'h77;
    evict_dirty = 0; evict_hits = 3'd2;
    repeat (3) @(posedge clk);
    #1;
    check(evict_ready == 1'b0, "R6 evict_ready low while pending", {{DATA_W{1'b0}}, evict_ready}, 0);
    check(mem_valid == 1'b1 && mem_addr == mk(30, 12) && mem_data == 64'h6666,
          "R6 write held", {1'b0, mem_data}, {1'b0, 64'h6666});
    evict_valid = 0;
    mem_ready = 1'b1;
    @(posedge clk); #1;
    @(posedge clk); #1;
    lookup(mk(31, 13), 0, '0, "R6 offered eviction not taken");

    repeat (5) @(posedge clk);
    #1;
    check(exp_resp_q.size() == 0, "R3 responses outstanding", exp_resp_q.size(), 0);
    check(exp_mem_q.size() == 0, "R4 memory writes outstanding", exp_mem_q.size(), 0);
    finish_run();
  end
endmodule